// File: doc/BRIEF.md
# Memory Calibration Stage Sequencer

This block steps a DDR-style memory PHY through a fixed calibration flow of seventeen numbered stages (0 to 16). For most stages it hands a command to one of three abstract workers: an admin/initialisation worker, a read-side gather worker and a write-side gather worker. It then waits for that worker to acknowledge and later finish. A finishing worker either passes or raises an error with an 8-bit result code. Every wait is bounded by a cycle timeout. The first failure stops the flow and freezes the failing stage number and a subcode in a 32-bit status word. Once all stages have passed, the sequencer settles in an operational state, where a tracking failure can still push it into the non-operational state.

The status word is visible on a port. It can also be read through a small memory-mapped debug read port that holds off the master for one cycle with waitrequest. A second debug location returns a mask of the stages that have passed. Restarting the calibration (`cal_start`) is allowed from idle, operational or non-operational. DRAM timing, PLL phase control and the datapath itself live in the workers and are not modelled here.

Top module: `cal_seq_top`

## Requirements
- R1: After start, stage 0 runs for one cycle and stage 1 follows. Stages 2 to 16 are then issued strictly in ascending order. Each issued stage raises exactly one bit of `wk_req` (bit 0 admin for stages 2, 3, 15; bit 2 write-gather for stages 4, 5, 6, 12, 14; bit 1 read-gather for all other stages) and shows its number on `wk_cmd`. The request is held until the matching `wk_ack` bit is seen.
- R2: Stage 1 (PHY init) issues no worker request. It advances only in a cycle where `dll_locked` and `init_done` are both high.
- R3: Stage 2 (DRAM init) is issued once per chip select. `wk_cs` counts 0 to NUM_CS-1, and each chip select needs its own acknowledge and done. Stage 3 follows only after the last chip select completes.
- R4: `wk_pattern` is 0x0F while stage 4 is requested or running, 0x35 while stage 5 or 6 is requested or running, and 0x00 otherwise.
- R5: A done with the matching `wk_err` bit set ends calibration in the non-operational state. Status bit 30 is set, bits [7:0] hold the failing stage and bits [23:16] hold that worker's byte of `wk_result` (worker k uses bits [8k+7:8k]).
- R6: If no acknowledge arrives within TIMEOUT_CYC cycles of a request, the result is non-operational. Status holds the stage, subcode 0xFD and bit 9 (ack-timeout flag).
- R7: A done that never arrives, or a PHY-init wait that lasts TIMEOUT_CYC cycles, gives non-operational. Status holds the stage, subcode 0xFE and bit 8 (done-timeout flag).
- R8: After stage 16 completes without error, the block is operational. Status is exactly 0x8000_0000, so the stage and subcode fields read zero, and all 17 pass-mask bits are set. Bit 29 is high only while stages are in progress.
- R9: In the operational state, a `trk_fail` pulse moves the block to non-operational with stage 16 and subcode `trk_code`.
- R10: A debug read holds `dbg_waitrequest` high in the first cycle of `dbg_rd` and low in the second, when `dbg_rd_data` is valid. Address 0 returns the status word, address 1 returns the pass mask in bits [16:0], and any other address returns zero.
- R11: After reset, and again after a restart, the status word is cleared. There is no request until the flow reaches a worker stage, and a fresh run replaces any earlier failure record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Begin (or restart) calibration |
| dll_locked | input | 1 | DLL lock indication for stage 1 |
| init_done | input | 1 | PHY init-done indication for stage 1 |
| wk_req | output | 3 | One-hot request to admin, read-gather, write-gather |
| wk_cmd | output | 5 | Stage number of the issued command |
| wk_cs | output | CS_W | Chip-select index for stage 2 |
| wk_pattern | output | 8 | Training pattern for pattern-writing stages |
| wk_ack | input | 3 | Per-worker acknowledge |
| wk_done | input | 3 | Per-worker completion |
| wk_err | input | 3 | Per-worker error, qualified by done |
| wk_result | input | 24 | Per-worker 8-bit result codes |
| trk_fail | input | 1 | Tracking failure in operational state |
| trk_code | input | 8 | Result code for a tracking failure |
| cal_status | output | 32 | Status word |
| cal_success | output | 1 | Operational |
| cal_fail | output | 1 | Non-operational |
| dbg_addr | input | 13 | Debug read address |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_rd_data | output | 32 | Debug read data |
| dbg_waitrequest | output | 1 | Debug wait request |

## Verification
A wrong internal stage or chip-select count shows on `wk_cmd`, `wk_cs` and `wk_req` in the very cycle the request rises, because those outputs come straight from registers. A timer that is off by one moves the cycle in which `cal_fail` and the subcode appear, and that shows within TIMEOUT_CYC+1 cycles of the stalled request. A stale failure record or a stray stage number left behind on success shows in the status word in the first cycle after the flow ends, before any debug read is made.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  localparam int unsigned STAGE_COUNT = 17;
  localparam int unsigned IDX_W       = $clog2(STAGE_COUNT);
  localparam int unsigned CMD_W       = 5;
  localparam int unsigned NWORK       = 3;
  localparam int unsigned RES_W       = 8;

  localparam logic [7:0] STG_ENTER = 8'd0;
  localparam logic [7:0] STG_PHY   = 8'd1;
  localparam logic [7:0] STG_DRAM  = 8'd2;
  localparam logic [7:0] STG_LAST  = 8'd16;

  localparam logic [7:0] SUB_ACK_TO  = 8'hFD;
  localparam logic [7:0] SUB_DONE_TO = 8'hFE;

  localparam logic [7:0] PAT_BLOCK = 8'h0F;
  localparam logic [7:0] PAT_MORE  = 8'h35;

  localparam logic [1:0] WK_ADMIN = 2'd0;
  localparam logic [1:0] WK_RDG   = 2'd1;
  localparam logic [1:0] WK_WRG   = 2'd2;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ENTER, SQ_PHY, SQ_REQ, SQ_WAIT, SQ_OPER, SQ_NONOP
  } sq_state_e;

  typedef struct packed {
    logic       success;
    logic       fail;
    logic       busy;
    logic [4:0] rsv_hi;
    logic [7:0] sub;
    logic [5:0] rsv_lo;
    logic       ack_to;
    logic       done_to;
    logic [7:0] stage;
  } cal_status_t;

  function automatic logic [1:0] stage_worker(input logic [7:0] s);
    logic [1:0] w;
    w = WK_RDG;
    if (s == 8'd2 || s == 8'd3 || s == 8'd15) w = WK_ADMIN;
    else if (s == 8'd4 || s == 8'd5 || s == 8'd6 || s == 8'd12 || s == 8'd14) w = WK_WRG;
    return w;
  endfunction

  function automatic logic [7:0] stage_pattern(input logic [7:0] s);
    logic [7:0] p;
    p = 8'h00;
    if (s == 8'd4) p = PAT_BLOCK;
    else if (s == 8'd5 || s == 8'd6) p = PAT_MORE;
    return p;
  endfunction

  function automatic cal_status_t pack_status(input sq_state_e st, input logic [7:0] stage,
                                              input logic [7:0] sub, input logic ato,
                                              input logic dto);
    cal_status_t r;
    r         = '0;
    r.success = (st == SQ_OPER);
    r.fail    = (st == SQ_NONOP);
    r.busy    = (st == SQ_ENTER) || (st == SQ_PHY) || (st == SQ_REQ) || (st == SQ_WAIT);
    r.stage   = (st == SQ_OPER) ? 8'h00 : stage;
    r.sub     = sub;
    r.ack_to  = ato;
    r.done_to = dto;
    return r;
  endfunction

  function automatic logic [31:0] dbg_mux(input logic [12:0] addr, input logic [31:0] status,
                                          input logic [STAGE_COUNT-1:0] mask);
    logic [31:0] d;
    d = 32'h0;
    if (addr == 13'd0) d = status;
    else if (addr == 13'd1) d = {{(32-STAGE_COUNT){1'b0}}, mask};
    return d;
  endfunction

endpackage

// File: rtl/cal_timeout.sv
module cal_timeout #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !run)    cnt <= '0;
    else if (!expired)       cnt <= cnt + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT)); // R7
  AST_TMR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt == '0); // R6

endmodule

// File: rtl/cal_pass_log.sv
module cal_pass_log import cal_seq_pkg::*; #(
  parameter int unsigned N = STAGE_COUNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             set,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (clr)  mask <= '0;
    else if (set)  mask <= mask | (N'(1) << idx);
  end

  AST_MASK_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> ((mask & $past(mask)) == $past(mask))); // R8

endmodule

// File: rtl/cal_dbg_rd.sv
module cal_dbg_rd import cal_seq_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [12:0]            dbg_addr,
  input  logic                   dbg_rd,
  input  logic [31:0]            status,
  input  logic [STAGE_COUNT-1:0] mask,
  output logic [31:0]            dbg_rd_data,
  output logic                   dbg_waitrequest
);
  logic second;
  logic take;

  assign take            = dbg_rd && !second;
  assign dbg_waitrequest = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second      <= 1'b0;
      dbg_rd_data <= '0;
    end else begin
      second <= take;
      if (take) dbg_rd_data <= dbg_mux(dbg_addr, status, mask);
    end
  end

  AST_WAIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_waitrequest |=> !dbg_waitrequest); // R10

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm import cal_seq_pkg::*; #(
  parameter int unsigned NUM_CS = 2,
  parameter int unsigned CS_W   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   dll_locked,
  input  logic                   init_done,
  input  logic [NWORK-1:0]       wk_ack,
  input  logic [NWORK-1:0]       wk_done,
  input  logic [NWORK-1:0]       wk_err,
  input  logic [NWORK*RES_W-1:0] wk_result,
  input  logic                   trk_fail,
  input  logic [7:0]             trk_code,
  input  logic                   tmr_expired,
  output logic                   tmr_run,
  output logic                   tmr_clr,
  output logic [NWORK-1:0]       wk_req,
  output logic [CMD_W-1:0]       wk_cmd,
  output logic [CS_W-1:0]        wk_cs,
  output logic [7:0]             wk_pattern,
  output logic                   pass_clr,
  output logic                   pass_set,
  output logic [IDX_W-1:0]       pass_idx,
  output cal_status_t            status
);
  localparam logic [CS_W-1:0] CS_LAST = CS_W'(NUM_CS - 1);

  sq_state_e      st, st_n;
  logic [7:0]     stage, stage_n;
  logic [CS_W-1:0] cs, cs_n;
  logic [7:0]     sub, sub_n;
  logic           ato, ato_n, dto, dto_n;
  logic [1:0]     w;
  logic [7:0]     w_res;

  assign w     = stage_worker(stage);
  assign w_res = wk_result[int'(w)*RES_W +: RES_W];

  always_comb begin
    st_n     = st;
    stage_n  = stage;
    cs_n     = cs;
    sub_n    = sub;
    ato_n    = ato;
    dto_n    = dto;
    tmr_clr  = 1'b0;
    pass_clr = 1'b0;
    pass_set = 1'b0;
    unique case (st)
      SQ_IDLE, SQ_OPER, SQ_NONOP: begin
        if (start) begin
          st_n     = SQ_ENTER;
          stage_n  = STG_ENTER;
          cs_n     = '0;
          sub_n    = 8'h00;
          ato_n    = 1'b0;
          dto_n    = 1'b0;
          pass_clr = 1'b1;
        end else if (st == SQ_OPER && trk_fail) begin
          st_n    = SQ_NONOP;
          stage_n = STG_LAST;
          sub_n   = trk_code;
        end
      end
      SQ_ENTER: begin
        pass_set = 1'b1;
        stage_n  = STG_PHY;
        st_n     = SQ_PHY;
        tmr_clr  = 1'b1;
      end
      SQ_PHY: begin
        if (dll_locked && init_done) begin
          pass_set = 1'b1;
          stage_n  = STG_DRAM;
          cs_n     = '0;
          st_n     = SQ_REQ;
          tmr_clr  = 1'b1;
        end else if (tmr_expired) begin
          st_n  = SQ_NONOP;
          sub_n = SUB_DONE_TO;
          dto_n = 1'b1;
        end
      end
      SQ_REQ: begin
        if (wk_ack[w]) begin
          st_n    = SQ_WAIT;
          tmr_clr = 1'b1;
        end else if (tmr_expired) begin
          st_n  = SQ_NONOP;
          sub_n = SUB_ACK_TO;
          ato_n = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (wk_done[w]) begin
          if (wk_err[w]) begin
            st_n  = SQ_NONOP;
            sub_n = w_res;
          end else if (stage == STG_DRAM && cs != CS_LAST) begin
            cs_n    = cs + 1'b1;
            st_n    = SQ_REQ;
            tmr_clr = 1'b1;
          end else begin
            pass_set = 1'b1;
            if (stage == STG_LAST) begin
              st_n = SQ_OPER;
            end else begin
              stage_n = stage + 8'd1;
              cs_n    = '0;
              st_n    = SQ_REQ;
              tmr_clr = 1'b1;
            end
          end
        end else if (tmr_expired) begin
          st_n  = SQ_NONOP;
          sub_n = SUB_DONE_TO;
          dto_n = 1'b1;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      stage <= STG_ENTER;
      cs    <= '0;
      sub   <= 8'h00;
      ato   <= 1'b0;
      dto   <= 1'b0;
    end else begin
      st    <= st_n;
      stage <= stage_n;
      cs    <= cs_n;
      sub   <= sub_n;
      ato   <= ato_n;
      dto   <= dto_n;
    end
  end

  assign tmr_run    = (st == SQ_PHY) || (st == SQ_REQ) || (st == SQ_WAIT);
  assign wk_req     = (st == SQ_REQ) ? (NWORK'(1) << w) : '0;
  assign wk_cmd     = stage[CMD_W-1:0];
  assign wk_cs      = cs;
  assign wk_pattern = (st == SQ_REQ || st == SQ_WAIT) ? stage_pattern(stage) : 8'h00;
  assign pass_idx   = stage[IDX_W-1:0];
  assign status     = pack_status(st, stage, sub, ato, dto);

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wk_req)); // R1
  AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_REQ && $past(st) == SQ_WAIT && stage != $past(stage))
      |-> stage == $past(stage) + 8'd1); // R1
  AST_PHY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_REQ && $past(st) == SQ_PHY) |-> $past(dll_locked && init_done)); // R2
  AST_CS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cs <= CS_LAST); // R3
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_NONOP && !start) |=> st == SQ_NONOP); // R5
  AST_ACKTO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ato |-> (sub == SUB_ACK_TO && st == SQ_NONOP)); // R6
  AST_DONETO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dto |-> (sub == SUB_DONE_TO && st == SQ_NONOP)); // R7

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top import cal_seq_pkg::*; #(
  parameter  int unsigned NUM_CS      = 2,
  parameter  int unsigned TIMEOUT_CYC = 1024,
  localparam int unsigned CS_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cal_start,
  input  logic            dll_locked,
  input  logic            init_done,
  output logic [2:0]      wk_req,
  output logic [4:0]      wk_cmd,
  output logic [CS_W-1:0] wk_cs,
  output logic [7:0]      wk_pattern,
  input  logic [2:0]      wk_ack,
  input  logic [2:0]      wk_done,
  input  logic [2:0]      wk_err,
  input  logic [23:0]     wk_result,
  input  logic            trk_fail,
  input  logic [7:0]      trk_code,
  output logic [31:0]     cal_status,
  output logic            cal_success,
  output logic            cal_fail,
  input  logic [12:0]     dbg_addr,
  input  logic            dbg_rd,
  output logic [31:0]     dbg_rd_data,
  output logic            dbg_waitrequest
);
  logic                   tmr_run, tmr_clr, tmr_expired;
  logic                   pass_clr, pass_set;
  logic [IDX_W-1:0]       pass_idx;
  logic [STAGE_COUNT-1:0] pass_mask;
  cal_status_t            status;

  cal_seq_fsm #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(cal_start),
    .dll_locked(dll_locked), .init_done(init_done),
    .wk_ack(wk_ack), .wk_done(wk_done), .wk_err(wk_err), .wk_result(wk_result),
    .trk_fail(trk_fail), .trk_code(trk_code),
    .tmr_expired(tmr_expired), .tmr_run(tmr_run), .tmr_clr(tmr_clr),
    .wk_req(wk_req), .wk_cmd(wk_cmd), .wk_cs(wk_cs), .wk_pattern(wk_pattern),
    .pass_clr(pass_clr), .pass_set(pass_set), .pass_idx(pass_idx),
    .status(status)
  );

  cal_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .clr(tmr_clr), .expired(tmr_expired)
  );

  cal_pass_log #(.N(STAGE_COUNT)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(pass_clr), .set(pass_set), .idx(pass_idx),
    .mask(pass_mask)
  );

  cal_dbg_rd u_dbg (
    .clk(clk), .rst_n(rst_n), .dbg_addr(dbg_addr), .dbg_rd(dbg_rd),
    .status(status), .mask(pass_mask),
    .dbg_rd_data(dbg_rd_data), .dbg_waitrequest(dbg_waitrequest)
  );

  assign cal_status  = status;
  assign cal_success = status.success;
  assign cal_fail    = status.fail;

  AST_OPER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cal_success |-> (&pass_mask)); // R8
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_success && cal_fail)); // R8

endmodule

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
  localparam int NCS = 2;
  localparam int TO  = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cal_start = 1'b0, dll_locked = 1'b0, init_done = 1'b0;
  logic [2:0]  wk_req;
  logic [4:0]  wk_cmd;
  logic [0:0]  wk_cs;
  logic [7:0]  wk_pattern;
  logic [2:0]  wk_ack = '0, wk_done = '0, wk_err = '0;
  logic [23:0] wk_result = '0;
  logic        trk_fail = 1'b0;
  logic [7:0]  trk_code = '0;
  logic [31:0] cal_status;
  logic        cal_success, cal_fail;
  logic [12:0] dbg_addr = '0;
  logic        dbg_rd = 1'b0;
  logic [31:0] dbg_rd_data;
  logic        dbg_waitrequest;

  always #5 clk = ~clk;

  cal_seq_top #(.NUM_CS(NCS), .TIMEOUT_CYC(TO)) dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .dll_locked(dll_locked),
    .init_done(init_done), .wk_req(wk_req), .wk_cmd(wk_cmd), .wk_cs(wk_cs),
    .wk_pattern(wk_pattern), .wk_ack(wk_ack), .wk_done(wk_done), .wk_err(wk_err),
    .wk_result(wk_result), .trk_fail(trk_fail), .trk_code(trk_code),
    .cal_status(cal_status), .cal_success(cal_success), .cal_fail(cal_fail),
    .dbg_addr(dbg_addr), .dbg_rd(dbg_rd), .dbg_rd_data(dbg_rd_data),
    .dbg_waitrequest(dbg_waitrequest)
  );

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // worker responder configuration
  int ack_dly = 1, done_dly = 2;
  int err_stage = -1, noack_stage = -1, nodone_stage = -1;
  logic [7:0] err_code = 8'h00;
  int rph = 0, rcnt = 0, rstg = 0;
  logic [2:0] rreq = '0;

  always @(negedge clk) begin
    wk_ack  = '0;
    wk_done = '0;
    wk_err  = '0;
    if (!rst_n || cal_start) begin
      rph = 0; rcnt = 0;
    end else if (rph == 0) begin
      if (wk_req != 0 && int'(wk_cmd) != noack_stage) begin
        if (rcnt >= ack_dly) begin
          wk_ack = wk_req; rreq = wk_req; rstg = int'(wk_cmd); rph = 1; rcnt = 0;
        end else rcnt++;
      end else rcnt = 0;
    end else if (rstg != nodone_stage) begin
      if (rcnt >= done_dly) begin
        wk_done = rreq;
        if (rstg == err_stage) begin
          wk_err    = rreq;
          wk_result = {3{err_code}};
        end
        rph = 0; rcnt = 0;
      end else rcnt++;
    end
  end

  // behavioural reference: phases 0 idle,1 enter,2 phy,3 request,4 running,5 oper,6 nonop
  int m_st = 0, m_stage = 0, m_cs = 0, m_cnt = 0;
  logic [7:0] m_sub = '0;
  bit m_ato = 0, m_dto = 0;

  function automatic int wk_of(int s);
    if (s == 2 || s == 3 || s == 15) return 0;
    if (s == 4 || s == 5 || s == 6 || s == 12 || s == 14) return 2;
    return 1;
  endfunction

  function automatic logic [7:0] pat_of(int s);
    if (s == 4) return 8'h0F;
    if (s == 5 || s == 6) return 8'h35;
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] v;
    v = '0;
    if (m_st == 5) v[31] = 1'b1;
    if (m_st == 6) v[30] = 1'b1;
    if (m_st >= 1 && m_st <= 4) v[29] = 1'b1;
    if (m_st != 5) v[7:0] = m_stage[7:0];
    v[23:16] = m_sub;
    v[8] = m_dto;
    v[9] = m_ato;
    return v;
  endfunction

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      m_st = 0; m_stage = 0; m_cs = 0; m_cnt = 0; m_sub = '0; m_ato = 0; m_dto = 0;
    end else begin
      w = wk_of(m_stage);
      if (m_st == 0 || m_st == 5 || m_st == 6) begin
        if (cal_start) begin
          m_st = 1; m_stage = 0; m_cs = 0; m_sub = '0; m_ato = 0; m_dto = 0;
        end else if (m_st == 5 && trk_fail) begin
          m_st = 6; m_stage = 16; m_sub = trk_code;
        end
      end else if (m_st == 1) begin
        m_st = 2; m_stage = 1; m_cnt = 0;
      end else if (m_st == 2) begin
        if (dll_locked && init_done) begin
          m_st = 3; m_stage = 2; m_cs = 0; m_cnt = 0;
        end else if (m_cnt == TO - 1) begin
          m_st = 6; m_sub = 8'hFE; m_dto = 1;
        end else m_cnt++;
      end else if (m_st == 3) begin
        if (wk_ack[w]) begin
          m_st = 4; m_cnt = 0;
        end else if (m_cnt == TO - 1) begin
          m_st = 6; m_sub = 8'hFD; m_ato = 1;
        end else m_cnt++;
      end else if (m_st == 4) begin
        if (wk_done[w]) begin
          if (wk_err[w]) begin
            m_st = 6; m_sub = wk_result[w*8 +: 8];
          end else if (m_stage == 2 && m_cs < NCS - 1) begin
            m_cs++; m_st = 3; m_cnt = 0;
          end else if (m_stage == 16) begin
            m_st = 5;
          end else begin
            m_stage++; m_cs = 0; m_st = 3; m_cnt = 0;
          end
        end else if (m_cnt == TO - 1) begin
          m_st = 6; m_sub = 8'hFE; m_dto = 1;
        end else m_cnt++;
      end
    end
  end

  // per-cycle comparison and issue log
  int   cmd_q[$];
  int   cs_q[$];
  logic [7:0] pat_seen [0:31];
  bit   req_prev = 0;

  always @(negedge clk) begin
    logic [2:0] er;
    if (rst_n) begin
      er = (m_st == 3) ? (3'b001 << wk_of(m_stage)) : 3'b000;
      chk(wk_req == er, "R1 req", {29'b0, wk_req}, {29'b0, er});
      if (er != 0) begin
        chk(int'(wk_cmd) == m_stage, "R1 cmd", {27'b0, wk_cmd}, m_stage);
        chk(int'(wk_cs) == m_cs, "R3 cs", {31'b0, wk_cs}, m_cs);
      end
      chk(wk_pattern == ((m_st == 3 || m_st == 4) ? pat_of(m_stage) : 8'h00), "R4 pattern",
          {24'b0, wk_pattern}, {24'b0, ((m_st == 3 || m_st == 4) ? pat_of(m_stage) : 8'h00)});
      chk(cal_status == exp_status(), "R8 status", cal_status, exp_status());
      if (wk_req != 0 && !req_prev) begin
        cmd_q.push_back(int'(wk_cmd));
        cs_q.push_back(int'(wk_cs));
        pat_seen[wk_cmd] = wk_pattern;
      end
      req_prev = (wk_req != 0);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #2;
  endtask

  task automatic do_start();
    @(negedge clk); #1 cal_start = 1'b1;
    @(negedge clk); #1 cal_start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #2;
      if (cal_success || cal_fail) break;
    end
  endtask

  task automatic dbg_read(input logic [12:0] a, output logic [31:0] d, output bit wok);
    bit w1, w2;
    @(negedge clk); #1 dbg_addr = a; dbg_rd = 1'b1;
    #1 w1 = dbg_waitrequest;
    @(negedge clk); #2 w2 = dbg_waitrequest; d = dbg_rd_data;
    dbg_rd = 1'b0;
    wok = w1 && !w2;
  endtask

  initial begin
    logic [31:0] d;
    bit wok;
    int exp_cmd[$];

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    tick(1);
    // R11 reset state
    chk(cal_status == 32'h0, "R11 reset status", cal_status, 32'h0);
    chk(wk_req == 3'b0, "R11 reset req", {29'b0, wk_req}, 32'h0);

    // Scenario A: full pass, PHY init gated on both indications
    do_start();
    tick(2);
    #1 dll_locked = 1'b1;
    tick(4);
    chk(cal_status[7:0] == 8'd1 && cal_status[29], "R2 held in phy init", cal_status, 32'h2000_0001);
    chk(wk_req == 3'b0, "R2 no request in phy init", {29'b0, wk_req}, 32'h0);
    #1 init_done = 1'b1;
    wait_end();
    chk(cal_success == 1'b1, "R8 success", {31'b0, cal_success}, 32'h1);
    chk(cal_status == 32'h8000_0000, "R8 zero fields", cal_status, 32'h8000_0000);
    for (int i = 0; i < NCS; i++) exp_cmd.push_back(2);
    for (int s = 3; s <= 16; s++) exp_cmd.push_back(s);
    chk(cmd_q.size() == exp_cmd.size(), "R1 issue count", cmd_q.size(), exp_cmd.size());
    for (int i = 0; i < exp_cmd.size() && i < cmd_q.size(); i++)
      chk(cmd_q[i] == exp_cmd[i], "R1 order", cmd_q[i], exp_cmd[i]);
    for (int i = 0; i < NCS && i < cs_q.size(); i++)
      chk(cs_q[i] == i, "R3 chip select", cs_q[i], i);
    chk(pat_seen[4] == 8'h0F, "R4 block pattern", {24'b0, pat_seen[4]}, 32'h0F);
    chk(pat_seen[5] == 8'h35, "R4 more pattern", {24'b0, pat_seen[5]}, 32'h35);
    chk(pat_seen[6] == 8'h35, "R4 test pattern", {24'b0, pat_seen[6]}, 32'h35);
    dbg_read(13'd1, d, wok);
    chk(wok, "R10 one wait cycle", {31'b0, wok}, 32'h1);
    chk(d == 32'h0001_FFFF, "R10 pass mask", d, 32'h0001_FFFF);
    dbg_read(13'd0, d, wok);
    chk(d == 32'h8000_0000 && wok, "R10 status read", d, 32'h8000_0000);
    dbg_read(13'd7, d, wok);
    chk(d == 32'h0, "R10 unmapped read", d, 32'h0);

    // Scenario B: tracking failure while operational
    @(negedge clk); #1 trk_fail = 1'b1; trk_code = 8'h5A;
    @(negedge clk); #1 trk_fail = 1'b0;
    tick(1);
    chk(cal_status == 32'h405A_0010, "R9 tracking failure", cal_status, 32'h405A_0010);

    // Scenario C: worker error in resync sweep, also restart clears
    err_stage = 8; err_code = 8'h33;
    do_start();
    #1;
    chk(cal_status[30] == 1'b0 && cal_status[23:16] == 8'h0, "R11 restart clears", cal_status, 32'h2000_0000);
    wait_end();
    chk(cal_status == 32'h4033_0008, "R5 worker error", cal_status, 32'h4033_0008);
    dbg_read(13'd1, d, wok);
    chk(d == 32'h0000_00FF, "R5 passed stages before failure", d, 32'h0000_00FF);

    // Scenario D: missing acknowledge at postamble
    err_stage = -1; noack_stage = 11;
    do_start();
    wait_end();
    chk(cal_status == 32'h40FD_020B, "R6 ack timeout", cal_status, 32'h40FD_020B);

    // Scenario E: missing done at read-latency stage
    noack_stage = -1; nodone_stage = 13;
    do_start();
    wait_end();
    chk(cal_status == 32'h40FE_010D, "R7 done timeout", cal_status, 32'h40FE_010D);

    // Scenario F: DLL never locks
    nodone_stage = -1;
    #1 dll_locked = 1'b0;
    do_start();
    wait_end();
    chk(cal_status == 32'h40FE_0101, "R7 phy init timeout", cal_status, 32'h40FE_0101);

    // Scenario G: chip-select ack slow, then success again
    #1 dll_locked = 1'b1; ack_dly = 3; done_dly = 0;
    cmd_q.delete(); cs_q.delete();
    do_start();
    wait_end();
    chk(cal_status == 32'h8000_0000, "R11 rerun success", cal_status, 32'h8000_0000);
    chk(cs_q.size() > 1 && cs_q[1] == 1, "R3 second chip select", cs_q.size(), 32'd17);

    tick(2);
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule